// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the clocked side of an analog comparator. The comparator's raw result bit arrives asynchronously. The block passes it through a synchronizer into the system clock and watches the synchronized value for a selected kind of transition: a rising edge, a falling edge, or either one. A qualifying transition sets a sticky interrupt flag. The block raises an interrupt request when the flag, the local enable and the global interrupt enable are all set. The synchronized bit can also be routed to a timer's capture trigger. The block drives the select lines that choose the comparator's positive and negative analog inputs.

Software controls the block through one 8-bit control/status register. It can write every bit except the synchronized output bit, which is read-only. It clears the flag by writing a one to it, and the interrupt controller clears the flag when it acknowledges the vector. A power-down bit freezes the synchronizer. While that bit is set, no transition events are produced.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset, `reg_rdata_o` reads 0x00 (the synchronized output bit is also 0). `irq_o`, `capture_trig_o`, `pos_sel_bandgap_o` and `cmp_pwr_dn_o` are all 0.
- R2: The register layout is: bit 7 power-down, bit 6 bandgap select, bit 5 synchronized output, bit 4 interrupt flag, bit 3 interrupt enable, bit 2 capture enable, bits 1:0 event mode. A write with `reg_wr_i` high loads bits 7, 6, 3, 2, 1 and 0. Bit 5 ignores writes.
- R3: `cmp_out_o` (and register bit 5) equals the value that `cmp_raw_i` had two rising clock edges earlier, as long as power-down stays clear.
- R4: The event mode selects which transition of the synchronized output sets the flag: 2'b00 any change, 2'b01 none, 2'b10 a 1-to-0 change, 2'b11 a 0-to-1 change. The flag is set on the edge after the synchronized output changes.
- R5: Writing with `reg_wdata_i[4]`=1 clears the flag, and writing 0 there leaves the flag unchanged. If an event and a clear arrive in the same cycle, the event wins and the flag stays set.
- R6: A pulse on `irq_ack_i` clears the flag, subject to the same priority as R5.
- R7: `irq_o` is 1 exactly when the flag, the interrupt enable bit and `gie_i` are all 1.
- R8: `capture_trig_o` follows `cmp_out_o` while capture enable is 1. It is 0 while capture enable is 0.
- R9: `pos_sel_bandgap_o` equals the bandgap select bit.
- R10: `neg_sel_adcmux_o` is 1 only when `mux_sel_en_i` is 1 and `adc_en_i` is 0.
- R11: `cmp_pwr_dn_o` equals the power-down bit. While that bit is set, the synchronized output holds its value and no event sets the flag.
- R12: One transition sets the flag once. After the flag is cleared, it stays clear while the raw input is steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Raw, asynchronous comparator result |
| adc_en_i | input | 1 | The ADC is enabled |
| mux_sel_en_i | input | 1 | Multiplexer-enable bit from the system control register |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt vector acknowledge pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| cmp_out_o | output | 1 | Synchronized comparator output |
| irq_o | output | 1 | Interrupt request |
| capture_trig_o | output | 1 | Trigger to the timer capture input |
| pos_sel_bandgap_o | output | 1 | Positive input selects the bandgap reference |
| neg_sel_adcmux_o | output | 1 | Negative input selects the ADC multiplexer |
| cmp_pwr_dn_o | output | 1 | Comparator power-down |

## Verification
The raw input is driven with single pulses, slow square waves and a long pseudo-random stream, under each of the four event modes. This shows whether rising-only, falling-only, toggle and reserved settings select different transitions. Flag clears by write and by acknowledge are placed both on quiet cycles and on the same cycle as an event, which separates the set-over-clear priority from a plain clear. The raw input keeps toggling while power-down is set, to show that the synchronizer freezes. The ADC-enable and multiplexer-enable pair, the capture enable and the global enable are each swept through all their combinations.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_NONE   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } evt_mode_e;

  localparam int REG_W   = 8;
  localparam int B_PWRDN = 7;
  localparam int B_BGAP  = 6;
  localparam int B_OUT   = 5;
  localparam int B_FLAG  = 4;
  localparam int B_IEN   = 3;
  localparam int B_CAPEN = 2;

  typedef struct packed {
    logic      pwrdn;
    logic      bgap;
    logic      ien;
    logic      capen;
    evt_mode_e mode;
  } ctrl_t;

  // Decide whether a transition from prev to cur matches the selected mode.
  function automatic logic edge_hit(evt_mode_e m, logic cur, logic prev);
    case (m)
      MODE_TOGGLE: return cur ^ prev;
      MODE_FALL:   return prev & ~cur;
      MODE_RISE:   return cur & ~prev;
      default:     return 1'b0;
    endcase
  endfunction

  // Assemble the read view of the control/status register.
  function automatic logic [REG_W-1:0] pack_status(ctrl_t c, logic outb, logic flag);
    return {c.pwrdn, c.bgap, outb, flag, c.ien, c.capen, c.mode};
  endfunction

  // Extract the writable fields from a write word.
  function automatic ctrl_t unpack_ctrl(logic [REG_W-1:0] w);
    ctrl_t c;
    c.pwrdn = w[B_PWRDN];
    c.bgap  = w[B_BGAP];
    c.ien   = w[B_IEN];
    c.capen = w[B_CAPEN];
    c.mode  = evt_mode_e'(w[1:0]);
    return c;
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic hold_i,
  output logic sync_o
);
  logic [STAGES-1:0] shr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       shr_q <= '0;
        else if (!hold_i) shr_q <= raw_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       shr_q <= '0;
        else if (!hold_i) shr_q <= {shr_q[STAGES-2:0], raw_i};
    end
  endgenerate

  assign sync_o = shr_q[STAGES-1];

  p_hold_freezes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(sync_o));
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_i,
  input  logic      en_i,
  input  evt_mode_e mode_i,
  output logic      hit_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_i;

  assign hit_o = en_i & edge_hit(mode_i, sync_i, prev_q);

  p_hit_on_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> $stable(sync_i) |-> !hit_o);
  p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_NONE) |-> !hit_o);
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !set_i |=> !flag_o);
  p_rise_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw_i,
  input  logic             adc_en_i,
  input  logic             mux_sel_en_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             cmp_out_o,
  output logic             irq_o,
  output logic             capture_trig_o,
  output logic             pos_sel_bandgap_o,
  output logic             neg_sel_adcmux_o,
  output logic             cmp_pwr_dn_o
);
  ctrl_t ctrl_q;
  logic  sync_out;
  logic  evt_hit;
  logic  flag_clr;
  logic  flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ctrl_q <= '0;
    else if (reg_wr_i) ctrl_q <= unpack_ctrl(reg_wdata_i);

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(cmp_raw_i),
    .hold_i(ctrl_q.pwrdn), .sync_o(sync_out));

  cmp_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_out),
    .en_i(~ctrl_q.pwrdn), .mode_i(ctrl_q.mode), .hit_o(evt_hit));

  assign flag_clr = irq_ack_i | (reg_wr_i & reg_wdata_i[B_FLAG]);

  cmp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(evt_hit),
    .clr_i(flag_clr), .flag_o(flag_q));

  assign cmp_out_o         = sync_out;
  assign irq_o             = flag_q & ctrl_q.ien & gie_i;
  assign capture_trig_o    = ctrl_q.capen & sync_out;
  assign pos_sel_bandgap_o = ctrl_q.bgap;
  assign neg_sel_adcmux_o  = mux_sel_en_i & ~adc_en_i;
  assign cmp_pwr_dn_o      = ctrl_q.pwrdn;
  assign reg_rdata_o       = pack_status(ctrl_q, sync_out, flag_q);

  p_no_event_pwrdn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pwr_dn_o && !flag_q |=> !flag_q || $past(reg_wr_i));
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !irq_o);
  p_cap_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[B_CAPEN] |-> !capture_trig_o);
  p_adc_blocks_mux_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en_i |-> !neg_sel_adcmux_o);
  p_out_bit_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[B_OUT] == cmp_out_o);
endmodule

// File: tb/tb_cmp_evt_ctrl.sv
module tb_cmp_evt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_raw_i = 0, adc_en_i = 0, mux_sel_en_i = 0, gie_i = 0, irq_ack_i = 0, reg_wr_i = 0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic cmp_out_o, irq_o, capture_trig_o, pos_sel_bandgap_o, neg_sel_adcmux_o, cmp_pwr_dn_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  bit q_pipe[$];
  bit m_prev = 0, m_flag = 0;
  bit [7:0] m_ctl = 8'h00;   // writable bits only; bits 5 and 4 kept 0

  always #10 clk = ~clk;     // 50 MHz

  cmp_evt_ctrl dut (.*);

  function automatic bit m_out();
    return q_pipe[0];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit [7:0] er;
    er = m_ctl;
    er[5] = m_out();
    er[4] = m_flag;
    check("R2 register", reg_rdata_o, er);
    check("R3 cmp_out", {7'd0, cmp_out_o}, {7'd0, m_out()});
    check("R7 irq", {7'd0, irq_o}, {7'd0, m_flag & m_ctl[3] & gie_i});
    check("R8 capture", {7'd0, capture_trig_o}, {7'd0, m_ctl[2] & m_out()});
    check("R9 bandgap", {7'd0, pos_sel_bandgap_o}, {7'd0, m_ctl[6]});
    check("R10 negsel", {7'd0, neg_sel_adcmux_o}, {7'd0, mux_sel_en_i & ~adc_en_i});
    check("R11 pwrdn", {7'd0, cmp_pwr_dn_o}, {7'd0, m_ctl[7]});
  endtask

  task automatic step();
    bit cur, ev, clr;
    @(posedge clk);
    cur = m_out();
    ev = 0;
    if (!m_ctl[7]) begin
      case (m_ctl[1:0])
        2'b00: ev = cur != m_prev;
        2'b10: ev = m_prev && !cur;
        2'b11: ev = !m_prev && cur;
        default: ev = 0;
      endcase
    end
    clr = irq_ack_i || (reg_wr_i && reg_wdata_i[4]);
    if (ev) m_flag = 1;
    else if (clr) m_flag = 0;
    m_prev = cur;
    if (!m_ctl[7]) begin
      void'(q_pipe.pop_front());
      q_pipe.push_back(cmp_raw_i);
    end
    if (reg_wr_i) m_ctl = reg_wdata_i & 8'hCF;
    #2;
    compare_all();
  endtask

  task automatic wr(bit [7:0] d);
    reg_wr_i = 1; reg_wdata_i = d;
    step();
    reg_wr_i = 0; reg_wdata_i = 8'h00;
  endtask

  task automatic raw_run(bit v, int n);
    cmp_raw_i = v;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    q_pipe.push_back(0); q_pipe.push_back(0);
    #25;
    compare_all();                         // R1 during reset
    check("R1 reset read", reg_rdata_o, 8'h00);
    #10 rst_n = 1;
    #7;
    step();
    check("R1 flag clear", {7'd0, irq_o}, 8'h00);

    // R2: all writable bits, bit 5 ignored
    wr(8'hFF); step();
    wr(8'h00); step();

    // R4 toggle mode (00), R7 with gie and ien
    gie_i = 1;
    wr(8'h08);
    raw_run(1, 4);
    check("R4 toggle rise sets flag", {7'd0, irq_o}, 8'h01);
    wr(8'h18);                             // R5 write-one clears
    check("R5 w1c", reg_rdata_o[4], 1'b0);
    raw_run(1, 4);                         // R12 steady: stays clear
    raw_run(0, 4);
    // R6 acknowledge clear
    irq_ack_i = 1; step(); irq_ack_i = 0; step();
    check("R6 ack clear", reg_rdata_o[4], 1'b0);

    // R4 rise mode: falling must not set
    wr(8'h0B);
    raw_run(1, 4); wr(8'h1B); raw_run(0, 5);
    check("R4 rise ignores fall", reg_rdata_o[4], 1'b0);
    // R4 fall mode
    wr(8'h0A);
    raw_run(1, 5);
    check("R4 fall ignores rise", reg_rdata_o[4], 1'b0);
    raw_run(0, 4);
    check("R4 fall sets", reg_rdata_o[4], 1'b1);
    wr(8'h1A);
    // R5 writing 0 to flag keeps it
    raw_run(1, 3); raw_run(0, 4);
    wr(8'h0A);
    check("R5 write zero keeps flag", reg_rdata_o[4], 1'b1);
    // R4 reserved mode
    wr(8'h19);
    raw_run(1, 4); raw_run(0, 4); raw_run(1, 4);
    check("R4 reserved no event", reg_rdata_o[4], 1'b0);

    // R5/R6 same-cycle set and clear: set wins
    wr(8'h08);
    cmp_raw_i = 0; step(); step();        // sync goes 1->0 on second edge
    irq_ack_i = 1; step(); irq_ack_i = 0; step();
    raw_run(1, 1); step();
    wr(8'h18);
    check("R5 set beats clear", reg_rdata_o[4], m_flag);

    // R7 gie gating
    gie_i = 0; step(); gie_i = 1; step();

    // R11 power-down freezes
    wr(8'h98);                             // clear flag, pwrdn, toggle mode
    for (int i = 0; i < 10; i++) raw_run(i[0], 1);
    check("R11 no event while down", reg_rdata_o[4], 1'b0);
    wr(8'h08); raw_run(cmp_raw_i, 4);

    // R8, R9, R10 sweeps
    wr(8'h44);
    raw_run(0, 3); raw_run(1, 3); raw_run(0, 3);
    for (int i = 0; i < 4; i++) begin
      mux_sel_en_i = i[0]; adc_en_i = i[1]; step();
    end
    wr(8'h10);

    // pseudo-random soak over all modes
    for (int i = 0; i < 1500; i++) begin
      cmp_raw_i = $urandom_range(0, 1);
      gie_i = $urandom_range(0, 1);
      irq_ack_i = ($urandom_range(0, 15) == 0);
      mux_sel_en_i = $urandom_range(0, 1);
      adc_en_i = $urandom_range(0, 1);
      if ($urandom_range(0, 19) == 0) begin
        reg_wr_i = 1;
        reg_wdata_i = 8'($urandom_range(0, 255)) & 8'h7F;
        if ($urandom_range(0, 7) == 0) reg_wdata_i[7] = 1;
      end
      step();
      reg_wr_i = 0; irq_ack_i = 0;
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at %0t: actual hung expected done", $time);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule